// File: doc/BRIEF.md
# Dual Maskable Time Alarm Comparator

This block watches a running time-of-day and calendar value and compares it with two alarm settings. Each alarm has a programmed value for six fields (second, minute, hour, day of week, date, month) and one enable bit per field. The comparison runs only in a cycle where the one-second tick is high. When every enabled field equals the current time, the alarm fires and sets a status flag. The flag stays set until the host clears it.

The interrupt output is active low and behaves like an open-drain pin: 0 means pull the line low and 1 means release it. It is low while any status flag is set whose interrupt enable is also set. A one-shot alarm disarms itself when it fires. An alarm in repeat mode stays armed, so it fires on every matching tick and gives a periodic interrupt. The host arms and disarms each alarm with single-cycle pulses and clears flags with a single-cycle pulse.

Each alarm is a four-state machine. The state is the pair {flag, armed}:

- `ST_IDLE`: no flag, not armed.
- `ST_ARMED`: no flag, armed.
- `ST_HELD_IDLE`: flag set, not armed.
- `ST_HELD_ARMED`: flag set, armed.

Transitions:

- **Arm:** from either idle state to the matching armed state.
- **Fire:** from an armed state to `ST_HELD_IDLE` (one-shot) or to `ST_HELD_ARMED` (repeat).
- **Clear:** from a held state to the matching flag-free state.
- **Disarm:** from an armed state to the matching idle state.

Top module: `dualalm_top`

## Requirements
- R1: After reset, both flags read 0, both alarms are disarmed and `irq_n` is 1 (released).
- R2: Each time vector packs the fields with the second in bits [5:0], minute in [11:6], hour in [16:12], day of week in [19:17], date in [24:20] and month in [28:25]. Alarm k uses the slice [29k+28:29k] of `alm_time`. An armed alarm fires when every enabled field equals the matching field of `now_time`.
- R3: Field enables for alarm k are `alm_fen[6k+5:6k]`, with bit 0 for second, 1 for minute, 2 for hour, 3 for day of week, 4 for date and 5 for month. A disabled field always counts as matching. An enabled field that differs blocks the alarm.
- R4: An alarm whose six enable bits are all 0 never fires.
- R5: After each clock edge, `irq_n` is 0 exactly when some alarm k has its flag set and `irq_en[k]` is 1. A change of `irq_en` shows on `irq_n` after the next edge.
- R6: An alarm with `alm_rpt[k]`=0 is disarmed by its own firing and does not fire again until it is re-armed.
- R7: An alarm fires only at an edge where `tick` is 1. The flag is visible right after that edge, and a match without a tick has no effect.
- R8: An alarm with `alm_rpt[k]`=1 stays armed after firing and fires again on each later matching tick.
- R9: A flag stays set until a `flag_clr[k]` pulse. If the alarm fires in the same cycle as the clear pulse, the flag stays set.
- R10: An `arm_set[k]` pulse arms the alarm and an `arm_clr[k]` pulse disarms it. When both pulse together, disarm wins. An arm pulse also wins over the self-disarm of a one-shot firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second strobe, one cycle wide |
| now_time | input | 29 | Current time and date, packed per R2 |
| alm_time | input | 58 | Alarm compare values, one 29-bit slice per alarm |
| alm_fen | input | 12 | Per-field enables, six bits per alarm |
| alm_rpt | input | 2 | Repeat mode per alarm |
| irq_en | input | 2 | Interrupt enable per alarm |
| arm_set | input | 2 | Arm pulse per alarm |
| arm_clr | input | 2 | Disarm pulse per alarm |
| flag_clr | input | 2 | Status clear pulse per alarm |
| alm_flag | output | 2 | Sticky status flag per alarm |
| alm_armed | output | 2 | Armed state per alarm |
| irq_n | output | 1 | Interrupt request, 0 = pull low, 1 = release |

## Verification
The assertions check these properties on every cycle:

- A flag rises only after a tick.
- A flag stays set until it is cleared.
- A disarm pulse always takes effect.
- A one-shot alarm is disarmed when its flag rises.
- An alarm with an empty mask cannot raise its flag.
- The interrupt line is released whenever no flag is set.

Only the bench scenarios can show the rest:

- Exact field decoding, including masked fields that differ.
- Periodic refiring in repeat mode.
- The fire-over-clear and disarm-over-arm priorities.
- The one-cycle lag between an interrupt-enable change and `irq_n`.

// File: rtl/dualalm_pkg.sv
package dualalm_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int DOW_W  = 3;
    localparam int DATE_W = 5;
    localparam int MON_W  = 4;
    localparam int NFIELD = 6;
    localparam int TIME_W = SEC_W + MIN_W + HR_W + DOW_W + DATE_W + MON_W;

    // Second sits in the least significant bits.
    typedef struct packed {
        logic [MON_W-1:0]  mon;
        logic [DATE_W-1:0] date;
        logic [DOW_W-1:0]  dow;
        logic [HR_W-1:0]   hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } tstamp_t;

    // Encoding is {flag, armed}.
    typedef enum logic [1:0] {
        ST_IDLE       = 2'b00,
        ST_ARMED      = 2'b01,
        ST_HELD_IDLE  = 2'b10,
        ST_HELD_ARMED = 2'b11
    } alm_state_t;

endpackage

// File: rtl/dualalm_match.sv
module dualalm_match
    import dualalm_pkg::*;
(
    input  tstamp_t           now,
    input  tstamp_t           cmp,
    input  logic [NFIELD-1:0] fen,
    output logic              hit
);

    logic [NFIELD-1:0] eq;

    always_comb begin
        eq  = {now.mon  == cmp.mon,
               now.date == cmp.date,
               now.dow  == cmp.dow,
               now.hour == cmp.hour,
               now.min  == cmp.min,
               now.sec  == cmp.sec};
        // A masked field is treated as equal; an empty mask never hits.
        hit = (|fen) && (&(eq | ~fen));
    end

endmodule

// File: rtl/dualalm_chan.sv
module dualalm_chan
    import dualalm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic rpt,
    input  logic arm_set,
    input  logic arm_clr,
    input  logic flag_clr,
    output logic flag,
    output logic armed,
    output logic flag_nxt
);

    alm_state_t state_q;
    alm_state_t state_d;
    logic       fire;
    logic       keep;
    logic       arm_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        fire    = 1'b0;
        keep    = 1'b0;
        arm_n   = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                state_d = (arm_set && !arm_clr) ? ST_ARMED : ST_IDLE;
            end
            ST_HELD_IDLE: begin
                arm_n   = arm_set && !arm_clr;
                keep    = !flag_clr;
                state_d = alm_state_t'({keep, arm_n});
            end
            ST_ARMED, ST_HELD_ARMED: begin
                fire    = tick && hit;
                // A firing keeps the flag even against a clear pulse.
                keep    = fire || (state_q == ST_HELD_ARMED && !flag_clr);
                arm_n   = !arm_clr && (arm_set || !fire || rpt);
                state_d = alm_state_t'({keep, arm_n});
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:       begin flag = 1'b0; armed = 1'b0; end
            ST_ARMED:      begin flag = 1'b0; armed = 1'b1; end
            ST_HELD_IDLE:  begin flag = 1'b1; armed = 1'b0; end
            ST_HELD_ARMED: begin flag = 1'b1; armed = 1'b1; end
            default:       begin flag = 1'b0; armed = 1'b0; end
        endcase
        flag_nxt = (state_d == ST_HELD_IDLE) || (state_d == ST_HELD_ARMED);
    end

endmodule

// File: rtl/dualalm_irq.sv
module dualalm_irq #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] flag_nxt,
    input  logic [NUM-1:0] irq_en,
    output logic           irq_n
);

    // Registered from the next flag value so the line moves with the flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else begin
            irq_n <= ~|(flag_nxt & irq_en);
        end
    end

endmodule

// File: rtl/dualalm_top.sv
module dualalm_top
    import dualalm_pkg::*;
#(
    parameter int NUM_ALARMS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic [TIME_W-1:0]            now_time,
    input  logic [NUM_ALARMS*TIME_W-1:0] alm_time,
    input  logic [NUM_ALARMS*NFIELD-1:0] alm_fen,
    input  logic [NUM_ALARMS-1:0]        alm_rpt,
    input  logic [NUM_ALARMS-1:0]        irq_en,
    input  logic [NUM_ALARMS-1:0]        arm_set,
    input  logic [NUM_ALARMS-1:0]        arm_clr,
    input  logic [NUM_ALARMS-1:0]        flag_clr,
    output logic [NUM_ALARMS-1:0]        alm_flag,
    output logic [NUM_ALARMS-1:0]        alm_armed,
    output logic                         irq_n
);

    tstamp_t                 now_s;
    logic [NUM_ALARMS-1:0]   hit;
    logic [NUM_ALARMS-1:0]   flag_nxt;

    assign now_s = tstamp_t'(now_time);

    for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_alm
        dualalm_match u_match (
            .now (now_s),
            .cmp (tstamp_t'(alm_time[k*TIME_W +: TIME_W])),
            .fen (alm_fen[k*NFIELD +: NFIELD]),
            .hit (hit[k])
        );

        dualalm_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .hit      (hit[k]),
            .rpt      (alm_rpt[k]),
            .arm_set  (arm_set[k]),
            .arm_clr  (arm_clr[k]),
            .flag_clr (flag_clr[k]),
            .flag     (alm_flag[k]),
            .armed    (alm_armed[k]),
            .flag_nxt (flag_nxt[k])
        );
    end

    dualalm_irq #(.NUM(NUM_ALARMS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_nxt (flag_nxt),
        .irq_en   (irq_en),
        .irq_n    (irq_n)
    );

endmodule

// File: rtl/dualalm_chk.sv
module dualalm_chk
    import dualalm_pkg::*;
#(
    parameter int NUM = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic [NUM*NFIELD-1:0] alm_fen,
    input logic [NUM-1:0]        alm_rpt,
    input logic [NUM-1:0]        arm_set,
    input logic [NUM-1:0]        arm_clr,
    input logic [NUM-1:0]        flag_clr,
    input logic [NUM-1:0]        alm_flag,
    input logic [NUM-1:0]        alm_armed,
    input logic                  irq_n
);

    for (genvar k = 0; k < NUM; k++) begin : g_prop
        // R7
        flag_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(alm_flag[k]) |-> $past(tick));

        // R9
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (alm_flag[k] && !flag_clr[k]) |=> alm_flag[k]);

        // R10
        disarm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            arm_clr[k] |=> !alm_armed[k]);

        // R6
        oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(alm_flag[k]) && !$past(alm_rpt[k]) && !$past(arm_set[k]))
            |-> !alm_armed[k]);

        // R4
        empty_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (alm_fen[k*NFIELD +: NFIELD] == '0 && !alm_flag[k]) |=> !alm_flag[k]);
    end

    // R5
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_flag == '0) |-> irq_n);

endmodule

bind dualalm_top dualalm_chk #(.NUM(NUM_ALARMS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .alm_fen   (alm_fen),
    .alm_rpt   (alm_rpt),
    .arm_set   (arm_set),
    .arm_clr   (arm_clr),
    .flag_clr  (flag_clr),
    .alm_flag  (alm_flag),
    .alm_armed (alm_armed),
    .irq_n     (irq_n)
);

// File: tb/dualalm_top_test.sv
module dualalm_top_test;
    import dualalm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NUM        = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    tick = 1'b0;
    logic [TIME_W-1:0]       now_time = '0;
    logic [NUM*TIME_W-1:0]   alm_time = '0;
    logic [NUM*NFIELD-1:0]   alm_fen = '0;
    logic [NUM-1:0]          alm_rpt = '0;
    logic [NUM-1:0]          irq_en = '0;
    logic [NUM-1:0]          arm_set = '0;
    logic [NUM-1:0]          arm_clr = '0;
    logic [NUM-1:0]          flag_clr = '0;
    logic [NUM-1:0]          alm_flag;
    logic [NUM-1:0]          alm_armed;
    logic                    irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        int             due;
        logic [NUM-1:0] flag;
        logic [NUM-1:0] armed;
        logic           irq;
        string          tag;
    } exp_t;

    exp_t sbq[$];
    logic [NUM-1:0] m_flag = '0;
    logic [NUM-1:0] m_armed = '0;

    dualalm_top #(.NUM_ALARMS(NUM)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .now_time(now_time),
        .alm_time(alm_time), .alm_fen(alm_fen), .alm_rpt(alm_rpt),
        .irq_en(irq_en), .arm_set(arm_set), .arm_clr(arm_clr),
        .flag_clr(flag_clr), .alm_flag(alm_flag), .alm_armed(alm_armed),
        .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    function automatic logic [TIME_W-1:0] tpack(int s, int mi, int h, int dw, int dt, int mo);
        tstamp_t t;
        t.sec  = SEC_W'(s);
        t.min  = MIN_W'(mi);
        t.hour = HR_W'(h);
        t.dow  = DOW_W'(dw);
        t.date = DATE_W'(dt);
        t.mon  = MON_W'(mo);
        return TIME_W'(t);
    endfunction

    // Field match per R2/R3/R4, written from the requirement text.
    function automatic logic m_hit(int k);
        tstamp_t a;
        tstamp_t n;
        logic [NFIELD-1:0] en;
        logic ok;
        a  = tstamp_t'(alm_time[k*TIME_W +: TIME_W]);
        n  = tstamp_t'(now_time);
        en = alm_fen[k*NFIELD +: NFIELD];
        ok = (en != '0);
        if (en[0] && a.sec  != n.sec)  ok = 1'b0;
        if (en[1] && a.min  != n.min)  ok = 1'b0;
        if (en[2] && a.hour != n.hour) ok = 1'b0;
        if (en[3] && a.dow  != n.dow)  ok = 1'b0;
        if (en[4] && a.date != n.date) ok = 1'b0;
        if (en[5] && a.mon  != n.mon)  ok = 1'b0;
        return ok;
    endfunction

    task automatic step(input string tag);
        exp_t e;
        for (int k = 0; k < NUM; k++) begin
            logic fire;
            fire = m_armed[k] && tick && m_hit(k);
            m_flag[k]  = fire || (m_flag[k] && !flag_clr[k]);
            m_armed[k] = arm_clr[k] ? 1'b0 : arm_set[k] ? 1'b1 : fire ? alm_rpt[k] : m_armed[k];
        end
        e.due   = cyc_cnt + 1;
        e.flag  = m_flag;
        e.armed = m_armed;
        e.irq   = ~|(m_flag & irq_en);
        e.tag   = tag;
        sbq.push_back(e);
        @(posedge clk);
        #1;
        tick     = 1'b0;
        arm_set  = '0;
        arm_clr  = '0;
        flag_clr = '0;
    endtask

    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc_cnt) begin
            exp_t e;
            e = sbq.pop_front();
            n_cmp++;
            if (alm_flag !== e.flag || alm_armed !== e.armed || irq_n !== e.irq) begin
                n_bad++;
                $display("FAIL %s: got flag=%b armed=%b irq_n=%b, expected flag=%b armed=%b irq_n=%b",
                         e.tag, alm_flag, alm_armed, irq_n, e.flag, e.armed, e.irq);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        step("R1 reset state");

        // One-shot alarm 0 on second 10
        alm_time[0 +: TIME_W] = tpack(10, 0, 0, 0, 0, 0);
        alm_fen[0 +: NFIELD]  = 6'b000001;
        irq_en  = 2'b01;
        arm_set = 2'b01;
        step("R10 arm alarm 0");
        now_time = tpack(10, 33, 7, 2, 15, 6);
        step("R7 match without tick ignored");
        tick = 1'b1;
        step("R2 R5 alarm 0 fires on second");
        tick = 1'b1;
        step("R6 one-shot holds flag, stays disarmed");
        flag_clr = 2'b01;
        step("R9 clear alarm 0 flag");
        tick = 1'b1;
        step("R6 disarmed alarm stays quiet");

        // Alarm 1 on minute and hour
        alm_time[TIME_W +: TIME_W] = tpack(0, 5, 3, 0, 0, 0);
        alm_fen[NFIELD +: NFIELD]  = 6'b000110;
        irq_en  = 2'b11;
        arm_set = 2'b10;
        step("R10 arm alarm 1");
        now_time = tpack(44, 5, 4, 1, 1, 1);
        tick = 1'b1;
        step("R3 enabled hour mismatch blocks");
        now_time = tpack(59, 5, 3, 6, 30, 12);
        tick = 1'b1;
        step("R3 masked fields ignored, alarm 1 fires");
        flag_clr = 2'b10;
        step("R9 clear alarm 1");

        // Empty mask
        alm_fen[NFIELD +: NFIELD] = 6'b000000;
        arm_set = 2'b10;
        step("R4 arm with empty mask");
        tick = 1'b1;
        step("R4 empty mask never fires");
        now_time = tpack(0, 0, 0, 0, 0, 0);
        tick = 1'b1;
        step("R4 empty mask with all-zero time");

        // Month field position
        alm_time[TIME_W +: TIME_W] = tpack(0, 0, 0, 0, 0, 12);
        alm_fen[NFIELD +: NFIELD]  = 6'b100000;
        now_time = tpack(7, 8, 9, 3, 4, 12);
        tick = 1'b1;
        step("R2 month field fires alarm 1");
        flag_clr = 2'b10;
        arm_clr  = 2'b10;
        step("R10 disarm and clear alarm 1");

        // Repeat mode on day-of-week and date
        alm_time[0 +: TIME_W] = tpack(0, 0, 0, 2, 15, 0);
        alm_fen[0 +: NFIELD]  = 6'b011000;
        alm_rpt = 2'b01;
        arm_set = 2'b01;
        step("R8 arm repeat alarm 0");
        now_time = tpack(1, 0, 0, 2, 15, 3);
        tick = 1'b1;
        step("R8 repeat fires and stays armed");
        flag_clr = 2'b01;
        step("R9 clear repeat flag");
        tick = 1'b1;
        step("R8 repeat fires again");
        flag_clr = 2'b01;
        tick = 1'b1;
        step("R9 fire wins over clear");
        flag_clr = 2'b01;
        step("R9 clear alarm 0 again");

        // Interrupt gating
        irq_en = 2'b00;
        tick = 1'b1;
        step("R5 flag set with interrupt disabled");
        irq_en = 2'b01;
        step("R5 enabling interrupt pulls line low");
        irq_en = 2'b10;
        step("R5 other enable leaves line released");

        // Arm/disarm priority
        arm_set = 2'b01;
        arm_clr = 2'b01;
        step("R10 disarm wins over arm");
        alm_rpt = 2'b00;
        flag_clr = 2'b01;
        arm_set = 2'b01;
        step("R10 re-arm one-shot");
        arm_set = 2'b01;
        tick = 1'b1;
        step("R10 arm pulse beats one-shot self-disarm");

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule